// File: doc/BRIEF.md
# Power Register Access Command Engine

This block executes batched register requests against a local file of byte-wide registers. A requester presents an opcode, a sub-command code, a byte count and a 20-byte payload, then pulses `start`. The engine checks that the request is well formed, takes a copy of the payload, and then walks the listed items one per clock. Depending on the sub-command, each item stores a byte, fetches a byte into a 16-byte response buffer, or merges a value under a bit mask.

The payload begins with a list of 16-bit register addresses, each stored low byte first. Any data bytes follow that list. When a request finishes, `done` pulses for one cycle. A request that is rejected gives the same pulse with `error` high and changes nothing.

The controller is a four-state machine. IDLE waits for `start`. From IDLE, a well-formed request moves to RUN and a malformed one moves to FAIL. RUN handles one item per cycle and moves to DONE after the last item. DONE and FAIL each last one cycle and return to IDLE.

Top module: `pwr_reg_engine`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, `resp` is all zero and every register holds zero.
- R2: Opcode 0xFF with sub-command 0 is a store request. It requires size = 3N. The address of item k is in payload bytes 2k (low) and 2k+1 (high). Its data byte is payload byte 2N+k, and it is written to that register.
- R3: Sub-command 1 is a fetch request. It requires size = 2N. Every accepted well-formed request first clears `resp`. A fetch then places the byte from item k's register in `resp` byte k (bits 8k+7:8k), and the remaining bytes stay zero.
- R4: Sub-command 2 is a masked update. It requires size 4. Payload bytes 0 and 1 hold the address, byte 2 the value and byte 3 the mask. The register becomes (old & ~mask) | (value & mask).
- R5: The request is rejected if the opcode is not 0xFF, the sub-command is above 2, the size does not fit the formula, or N is 0 or above 5. A rejected request pulses `done` with `error` high one cycle after acceptance, changes no register and leaves `resp` unchanged.
- R6: Only the low 8 bits of each 16-bit address select a register. The high byte is ignored.
- R7: For an accepted well-formed request with N items, `done` is high for exactly one cycle, N cycles after the cycle in which `start` was taken. `busy` is high from acceptance until that cycle ends.
- R8: `start` is ignored while `busy` is high, including the cycle in which `done` is high.
- R9: Items are processed in list order, so a later store to the same register wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| opcode | input | 8 | Request opcode, 0xFF accepted |
| sub_id | input | 4 | Sub-command: 0 store, 1 fetch, 2 masked update |
| size | input | 8 | Payload byte count |
| payload | input | 160 | Payload, byte i at bits 8i+7:8i |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with `done` when a request is rejected |
| resp | output | 128 | Response buffer, byte k at bits 8k+7:8k |

## Verification
A new `start` can arrive in the same cycle that the engine is still working, or in the same cycle that it reports completion on `done`. In both cases the engine must not take it. The bench provokes both. In one case it holds `start` high, carrying a store to a fresh register, during the cycle right after a request is accepted. In the other it raises `start` in the exact cycle where `done` is seen. The scoreboard reports any completion pulse it was not expecting. A later fetch then shows that the fresh register still holds zero.

// File: rtl/pre_pkg.sv
package pre_pkg;

    localparam logic [7:0] PRE_OPCODE = 8'hFF;

    localparam logic [3:0] PRE_SUB_STORE = 4'd0;
    localparam logic [3:0] PRE_SUB_FETCH = 4'd1;
    localparam logic [3:0] PRE_SUB_MERGE = 4'd2;

    typedef enum logic [1:0] {
        KIND_STORE = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_MERGE = 2'd2,
        KIND_NONE  = 2'd3
    } pre_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_FAIL = 2'd3
    } pre_state_e;

endpackage

// File: rtl/pre_decode.sv
module pre_decode
    import pre_pkg::*;
#(
    parameter int MAX_ITEMS = 5,
    parameter int CNT_W     = 3
) (
    input  logic [7:0]       opcode,
    input  logic [3:0]       sub_id,
    input  logic [7:0]       size,
    output logic             req_ok,
    output pre_kind_e        req_kind,
    output logic [CNT_W-1:0] req_count
);

    logic [7:0] items;

    always_comb begin
        req_ok   = 1'b0;
        req_kind = KIND_NONE;
        items    = 8'd0;
        if (opcode == PRE_OPCODE) begin
            unique case (sub_id)
                PRE_SUB_STORE: begin
                    req_kind = KIND_STORE;
                    items    = size / 8'd3;
                    req_ok   = ((size % 8'd3) == 8'd0);
                end
                PRE_SUB_FETCH: begin
                    req_kind = KIND_FETCH;
                    items    = size / 8'd2;
                    req_ok   = ((size % 8'd2) == 8'd0);
                end
                PRE_SUB_MERGE: begin
                    req_kind = KIND_MERGE;
                    items    = 8'd1;
                    req_ok   = (size == 8'd4);
                end
                default: begin
                    req_kind = KIND_NONE;
                    req_ok   = 1'b0;
                end
            endcase
        end
        if (items == 8'd0 || items > 8'(MAX_ITEMS)) begin
            req_ok = 1'b0;
        end
        req_count = req_ok ? items[CNT_W-1:0] : '0;
    end

endmodule

// File: rtl/pre_regfile.sv
module pre_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pwr_reg_engine.sv
module pwr_reg_engine
    import pre_pkg::*;
#(
    parameter int PAY_BYTES  = 20,
    parameter int RESP_BYTES = 16,
    parameter int MAX_ITEMS  = 5,
    parameter int AW         = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [7:0]              opcode,
    input  logic [3:0]              sub_id,
    input  logic [7:0]              size,
    input  logic [PAY_BYTES*8-1:0]  payload,
    output logic                    busy,
    output logic                    done,
    output logic                    error,
    output logic [RESP_BYTES*8-1:0] resp
);

    localparam int CNT_W = $clog2(MAX_ITEMS + 1);
    localparam int PIW   = $clog2(PAY_BYTES);
    localparam int RIW   = $clog2(RESP_BYTES);

    pre_state_e       state_q, state_d;
    pre_kind_e        kind_q;
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic [7:0]       pl_q   [PAY_BYTES];
    logic [7:0]       resp_q [RESP_BYTES];

    logic             dec_ok;
    pre_kind_e        dec_kind;
    logic [CNT_W-1:0] dec_cnt;
    logic             accept;
    logic             last_item;

    logic [PIW-1:0]   a_lo, a_hi, d_idx;
    logic [15:0]      item_addr;
    logic [7:0]       item_data;
    logic [7:0]       rf_rdata, rf_wdata;
    logic             rf_we;

    pre_decode #(
        .MAX_ITEMS (MAX_ITEMS),
        .CNT_W     (CNT_W)
    ) u_decode (
        .opcode    (opcode),
        .sub_id    (sub_id),
        .size      (size),
        .req_ok    (dec_ok),
        .req_kind  (dec_kind),
        .req_count (dec_cnt)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign last_item = (idx_q == cnt_q - CNT_W'(1));

    // item field selection from the captured payload
    always_comb begin
        a_lo      = PIW'({idx_q, 1'b0});
        a_hi      = a_lo + PIW'(1);
        d_idx     = PIW'({cnt_q, 1'b0}) + PIW'(idx_q);
        item_addr = {pl_q[a_hi], pl_q[a_lo]};
        item_data = pl_q[d_idx];
    end

    always_comb begin
        rf_we    = (state_q == ST_RUN) && (kind_q != KIND_FETCH);
        rf_wdata = item_data;
        if (kind_q == KIND_MERGE) begin
            rf_wdata = (rf_rdata & ~pl_q[3]) | (pl_q[2] & pl_q[3]);
        end
    end

    pre_regfile #(
        .AW (AW),
        .DW (8)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (item_addr[AW-1:0]),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = dec_ok ? ST_RUN : ST_FAIL;
            ST_RUN:  if (last_item) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
        endcase
    end

    // request capture and item datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_NONE;
            cnt_q  <= '0;
            idx_q  <= '0;
            for (int i = 0; i < PAY_BYTES; i++) pl_q[i] <= '0;
            for (int i = 0; i < RESP_BYTES; i++) resp_q[i] <= '0;
        end else if (accept) begin
            kind_q <= dec_kind;
            cnt_q  <= dec_cnt;
            idx_q  <= '0;
            for (int i = 0; i < PAY_BYTES; i++) pl_q[i] <= payload[8*i +: 8];
            if (dec_ok) begin
                for (int i = 0; i < RESP_BYTES; i++) resp_q[i] <= '0;
            end
        end else if (state_q == ST_RUN) begin
            idx_q <= idx_q + CNT_W'(1);
            if (kind_q == KIND_FETCH) begin
                resp_q[RIW'(idx_q)] <= rf_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q != ST_IDLE);
        done  = (state_q == ST_DONE) || (state_q == ST_FAIL);
        error = (state_q == ST_FAIL);
        for (int i = 0; i < RESP_BYTES; i++) resp[8*i +: 8] = resp_q[i];
    end

endmodule

// File: rtl/pre_checker.sv
module pre_checker #(
    parameter int RESP_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    error,
    input logic [RESP_BYTES*8-1:0] resp
);

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion only while a request is held
    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R5: rejection is flagged only with the completion pulse
    a_r5_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R7: an idle start is taken
    a_r7_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: work in progress is not dropped before completion
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3: the response buffer is quiet while idle
    a_r3_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(resp));

endmodule

bind pwr_reg_engine pre_checker #(.RESP_BYTES(RESP_BYTES)) u_pre_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .error (error),
    .resp  (resp)
);

// File: tb/pwr_reg_engine_test.sv
`timescale 1ns/1ps
module pwr_reg_engine_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   opcode = '0;
    logic [3:0]   sub_id = '0;
    logic [7:0]   size = '0;
    logic [159:0] payload = '0;
    logic         busy, done, error;
    logic [127:0] resp;

    always #2.5 clk = ~clk;

    pwr_reg_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .sub_id(sub_id), .size(size), .payload(payload),
        .busy(busy), .done(done), .error(error), .resp(resp)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [7:0]   model_rf [256];
    logic [7:0]   pb [20];
    logic [127:0] last_resp = '0;

    bit           q_err  [$];
    logic [127:0] q_resp [$];
    int           q_lat  [$];
    int           q_cyc  [$];
    string        q_tag  [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_pb();
        for (int i = 0; i < 20; i++) pb[i] = 8'h00;
    endtask

    // monitor: pops one expectation per completion pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_err.size() == 0) begin
                check(1'b0, "R8 unexpected done", 128'd1, 128'd0);
            end else begin
                bit e;
                logic [127:0] r;
                int l, c;
                string t;
                e = q_err.pop_front();
                r = q_resp.pop_front();
                l = q_lat.pop_front();
                c = q_cyc.pop_front();
                t = q_tag.pop_front();
                check(error == e, {t, " error"}, 128'(error), 128'(e));
                check(resp == r, {t, " resp"}, resp, r);
                check((cyc - c) == l, {"R7 latency ", t}, 128'(cyc - c), 128'(l));
            end
        end
    end

    // driver: computes expectation from the requirements, then issues the request
    task automatic send(input logic [7:0] opc, input logic [3:0] sub, input logic [7:0] sz,
                        input string tag, input int poke);
        bit ok;
        int n;
        logic [127:0] er;
        ok = 0;
        n = 0;
        if (opc == 8'hFF) begin
            if (sub == 4'd0 && (sz % 3) == 0) begin n = sz / 3; ok = 1; end
            if (sub == 4'd1 && (sz % 2) == 0) begin n = sz / 2; ok = 1; end
            if (sub == 4'd2 && sz == 8'd4)    begin n = 1;      ok = 1; end
        end
        if (n < 1 || n > 5) ok = 0;
        er = last_resp;
        if (ok) begin
            er = '0;
            for (int k = 0; k < n; k++) begin
                logic [7:0] a;
                a = pb[2*k];
                if (sub == 4'd0) model_rf[a] = pb[2*n + k];
                else if (sub == 4'd1) er[8*k +: 8] = model_rf[a];
                else model_rf[a] = (model_rf[a] & ~pb[3]) | (pb[2] & pb[3]);
            end
        end
        last_resp = er;
        q_err.push_back(!ok);
        q_resp.push_back(er);
        q_lat.push_back(ok ? n : 0);
        q_tag.push_back(tag);

        @(negedge clk);
        opcode = opc;
        sub_id = sub;
        size   = sz;
        for (int i = 0; i < 20; i++) payload[8*i +: 8] = pb[i];
        start = 1'b1;
        q_cyc.push_back(cyc + 1);
        @(negedge clk);
        if (poke == 1) begin
            // R8: start held during the first working cycle, store 0xEE to reg 0x77
            opcode = 8'hFF; sub_id = 4'd0; size = 8'd3;
            payload = '0;
            payload[7:0] = 8'h77; payload[23:16] = 8'hEE;
            @(negedge clk);
        end
        start = 1'b0;
        if (poke == 2) begin
            while (!done) @(negedge clk);
            // R8: start raised in the completion cycle
            opcode = 8'hFF; sub_id = 4'd0; size = 8'd3;
            payload = '0;
            payload[7:0] = 8'h77; payload[23:16] = 8'hEE;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fetch1(input logic [7:0] lo, input logic [7:0] hi, input string tag);
        clear_pb();
        pb[0] = lo; pb[1] = hi;
        send(8'hFF, 4'd1, 8'd2, tag, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model_rf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", 128'(busy), 128'd0);
        check(done == 1'b0, "R1 done", 128'(done), 128'd0);
        check(error == 1'b0, "R1 error", 128'(error), 128'd0);
        check(resp == '0, "R1 resp", resp, 128'd0);
        fetch1(8'h33, 8'h00, "R1 register zero");

        // R2 single store
        clear_pb(); pb[0] = 8'h10; pb[2] = 8'hA5;
        send(8'hFF, 4'd0, 8'd3, "R2 store one", 0);
        fetch1(8'h10, 8'h00, "R3 fetch one");

        // R2 five stores
        clear_pb();
        for (int k = 0; k < 5; k++) begin pb[2*k] = 8'(8'h20 + k); pb[10 + k] = 8'(k + 1); end
        send(8'hFF, 4'd0, 8'd15, "R2 store five", 0);

        // R3 five fetches in reverse order
        clear_pb();
        for (int k = 0; k < 5; k++) pb[2*k] = 8'(8'h24 - k);
        send(8'hFF, 4'd1, 8'd10, "R3 fetch five", 0);

        // R6 high address byte ignored
        clear_pb(); pb[0] = 8'h40; pb[1] = 8'h03; pb[2] = 8'h41; pb[3] = 8'hFF; pb[4] = 8'h5A; pb[5] = 8'hC3;
        send(8'hFF, 4'd0, 8'd6, "R6 store high byte", 0);
        fetch1(8'h40, 8'hFF, "R6 fetch alias");
        fetch1(8'h41, 8'h00, "R6 fetch plain");

        // R4 masked update: 0xA5 with value 0x0F mask 0x3C gives 0x8D
        clear_pb(); pb[0] = 8'h10; pb[2] = 8'h0F; pb[3] = 8'h3C;
        send(8'hFF, 4'd2, 8'd4, "R4 merge", 0);
        fetch1(8'h10, 8'h00, "R4 merge readback");

        // R9 ordering
        clear_pb(); pb[0] = 8'h50; pb[2] = 8'h50; pb[4] = 8'h51; pb[6] = 8'h11; pb[7] = 8'h22; pb[8] = 8'h33;
        send(8'hFF, 4'd0, 8'd9, "R9 store order", 0);
        clear_pb(); pb[0] = 8'h50; pb[2] = 8'h51;
        send(8'hFF, 4'd1, 8'd4, "R9 fetch order", 0);

        // R5 rejected requests aimed at reg 0x10
        clear_pb(); pb[0] = 8'h10; pb[2] = 8'h00; pb[3] = 8'hFF;
        send(8'hFE, 4'd0, 8'd3, "R5 bad opcode", 0);
        send(8'hFF, 4'd3, 8'd3, "R5 bad sub", 0);
        send(8'hFF, 4'd0, 8'd4, "R5 store size", 0);
        send(8'hFF, 4'd0, 8'd18, "R5 store six", 0);
        send(8'hFF, 4'd1, 8'd12, "R5 fetch six", 0);
        send(8'hFF, 4'd1, 8'd0, "R5 fetch zero", 0);
        send(8'hFF, 4'd2, 8'd6, "R5 merge size", 0);
        fetch1(8'h10, 8'h00, "R5 register kept");

        // R8 start while busy
        clear_pb(); pb[0] = 8'h60; pb[2] = 8'h61; pb[4] = 8'h01; pb[5] = 8'h02;
        send(8'hFF, 4'd0, 8'd6, "R8 poke run", 1);
        clear_pb(); pb[0] = 8'h62; pb[2] = 8'h03;
        send(8'hFF, 4'd0, 8'd3, "R8 poke done", 2);
        clear_pb(); pb[0] = 8'h77; pb[2] = 8'h60; pb[4] = 8'h62;
        send(8'hFF, 4'd1, 8'd6, "R8 ignored start", 0);

        repeat (4) @(negedge clk);
        check(q_err.size() == 0, "R7 pending completions", 128'(q_err.size()), 128'd0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog timeout");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule